// File: doc/BRIEF.md
# CPU Bus Address Decoder and Strobe Glue

This block sits beside a processor that has an 8-bit data bus and a 20-bit address bus. On every clock it looks at the upper address bits, the address strobe, the data strobe, the read/write line and the function code. From these it produces the chip selects for the on-board devices: a ROM output enable, two DRAM column-strobe selects and a peripheral chip enable. It also produces a kill signal when the address falls outside the local area, and a data strobe for the local memory controller. That local strobe is forced inactive while kill is asserted. The raw data strobe goes to the expansion port without change. During interrupt acknowledge the block requests autovectoring. It returns the transfer acknowledge itself for local cycles and relays the expansion port's acknowledge for external ones.

Every output is active low. Every output except the expansion strobe passes through one register stage. As a result, each decode appears one clock after the inputs that cause it, and each output is released one clock after the address strobe goes high. Bits 17:16 of the address choose among the local devices. Bit 15 chooses between the two DRAM column strobes. Bits 19:18 mark the expansion space. The read/write line sets the direction of the transfer. It does not change any decode, select or acknowledge, so any pattern below applies to both reads and writes.

Top module: `busGlue`

## Requirements
- R1: One clock after the inputs, romOeN is low exactly when asN is low, addr[19:18] is 00, addr[17:16] is 00, and fc[1:0] is not 11.
- R2: Under the same local conditions as R1, a value of 10 in addr[17:16] drives casN[0] low when addr[15] is 0 and casN[1] low when addr[15] is 1. A value of 01 drives perCeN low. A value of 11 drives no select. At most one of romOeN, casN[1:0] and perCeN is low at any time.
- R3: One clock after the inputs, killN is low exactly when asN is low, addr[19] or addr[18] is 1, and fc[1:0] is not 11.
- R4: locDsN is dsN delayed by one clock. It is forced high when asN was high or when the access was external (the condition of R3).
- R5: expDsN always equals dsN within the same cycle, whether or not the access is external.
- R6: One clock after the inputs, vpaN is low exactly when asN is low and fc[1] and fc[0] are both 1. In such a cycle no select, no kill and no acknowledge is asserted.
- R7: For a cycle that drives one of romOeN, casN or perCeN, dtackN goes low at the second consecutive clock edge that samples asN and dsN low. It stays low while both remain low. A local access with addr[17:16] = 11 gets no acknowledge.
- R8: During an external access (the condition of R3), dtackN is expDtackN delayed by one clock.
- R9: One clock after asN is sampled high, every registered output (romOeN, casN, perCeN, killN, locDsN, vpaN, dtackN) is high.
- R10: While rstN is low, every registered output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 20 | Processor address bus |
| asN | input | 1 | Address strobe, active low |
| dsN | input | 1 | Data strobe, active low |
| rwN | input | 1 | Read high, write low (does not affect decode) |
| fc | input | 3 | Processor function code |
| expDtackN | input | 1 | Transfer acknowledge from the expansion port, active low |
| romOeN | output | 1 | ROM output enable |
| casN | output | 2 | DRAM column-strobe selects, one per bank |
| perCeN | output | 1 | Peripheral chip enable |
| killN | output | 1 | External access in progress |
| locDsN | output | 1 | Gated data strobe to the local memory controller |
| expDsN | output | 1 | Raw data strobe to the expansion port |
| vpaN | output | 1 | Autovector request |
| dtackN | output | 1 | Transfer acknowledge to the processor |

## Verification
Two overlaps matter most. The first is an interrupt acknowledge whose address lies in the expansion space. Here both the autovector request and kill could fire, and the autovector must win: no kill, no select and no acknowledge. The second is an external access with the data strobe asserted. In that cycle kill must block the local strobe while the expansion strobe still follows the raw input. The bench drives both cases on purpose, then runs several hundred random cycles. It compares every output against a behavioural reference model on every clock.

// File: rtl/busGluePkg.sv
package busGluePkg;
  typedef struct packed {
    logic       qual;
    logic       iack;
    logic       ext;
    logic       rom;
    logic [1:0] cas;
    logic       per;
    logic       ds;
  } glueStrb_t;
endpackage

// File: rtl/busGlueCtl.sv
module busGlueCtl
  import busGluePkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SEL_LO   = 16,
  parameter int BANK_BIT = 15,
  parameter int NUM_CAS  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              asN,
  input  logic              dsN,
  input  logic [2:0]        fc,
  output glueStrb_t         strb
);
  localparam int EXT_HI = SEL_LO + 3;
  localparam int EXT_LO = SEL_LO + 2;

  logic       active;
  logic       extHit;
  logic       localHit;
  logic [1:0] devField;
  logic       dramHit;
  logic [NUM_CAS-1:0] casHit;

  always_comb begin
    active   = !asN && !(fc[1] && fc[0]);
    extHit   = active && (|addr[EXT_HI:EXT_LO]);
    localHit = active && !extHit;
    devField = addr[SEL_LO+1:SEL_LO];
    dramHit  = localHit && (devField == 2'b10);
  end

  for (genvar b = 0; b < NUM_CAS; b++) begin : g_cas
    assign casHit[b] = dramHit && (addr[BANK_BIT] == b[0]);
  end

  always_comb begin
    strb.qual = !asN;
    strb.iack = fc[1] && fc[0];
    strb.ext  = extHit;
    strb.rom  = localHit && (devField == 2'b00);
    strb.cas  = casHit;
    strb.per  = localHit && (devField == 2'b01);
    strb.ds   = !dsN;
  end
endmodule

// File: rtl/busGlueDp.sv
module busGlueDp
  import busGluePkg::*;
#(
  parameter int ACK_DELAY = 2,
  parameter int NUM_CAS   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  glueStrb_t          strb,
  input  logic               expDtackN,
  output logic               romOeN,
  output logic [NUM_CAS-1:0] casN,
  output logic               perCeN,
  output logic               killN,
  output logic               locDsN,
  output logic               vpaN,
  output logic               dtackN
);
  localparam int CNT_W = $clog2(ACK_DELAY + 1);
  localparam logic [CNT_W-1:0] ACK_AT  = CNT_W'(ACK_DELAY - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ACK_DELAY);

  logic [CNT_W-1:0] dsCnt;
  logic             devHit;
  logic             ackGo;
  logic             ackNow;

  always_comb begin
    devHit = strb.rom || (|strb.cas) || strb.per;
    ackGo  = devHit && strb.ds;
    ackNow = ackGo && (dsCnt >= ACK_AT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romOeN <= 1'b1;
      casN   <= '1;
      perCeN <= 1'b1;
      killN  <= 1'b1;
      locDsN <= 1'b1;
      vpaN   <= 1'b1;
      dtackN <= 1'b1;
      dsCnt  <= '0;
    end else begin
      romOeN <= !strb.rom;
      casN   <= ~strb.cas;
      perCeN <= !strb.per;
      killN  <= !strb.ext;
      locDsN <= !(strb.ds && strb.qual && !strb.ext);
      vpaN   <= !(strb.qual && strb.iack);
      dtackN <= strb.ext ? expDtackN : !ackNow;
      if (!ackGo)                dsCnt <= '0;
      else if (dsCnt != CNT_MAX) dsCnt <= dsCnt + 1'b1;
    end
  end
endmodule

// File: rtl/busGlue.sv
module busGlue
  import busGluePkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SEL_LO    = 16,
  parameter int BANK_BIT  = 15,
  parameter int ACK_DELAY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              asN,
  input  logic              dsN,
  input  logic              rwN,
  input  logic [2:0]        fc,
  input  logic              expDtackN,
  output logic              romOeN,
  output logic [1:0]        casN,
  output logic              perCeN,
  output logic              killN,
  output logic              locDsN,
  output logic              expDsN,
  output logic              vpaN,
  output logic              dtackN
);
  localparam int NUM_CAS = 2;

  glueStrb_t strb;
  logic      rwUnused;

  assign rwUnused = rwN;
  assign expDsN   = dsN;

  busGlueCtl #(
    .ADDR_W(ADDR_W), .SEL_LO(SEL_LO), .BANK_BIT(BANK_BIT), .NUM_CAS(NUM_CAS)
  ) u_ctl (
    .addr(addr), .asN(asN), .dsN(dsN), .fc(fc), .strb(strb)
  );

  busGlueDp #(
    .ACK_DELAY(ACK_DELAY), .NUM_CAS(NUM_CAS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .expDtackN(expDtackN),
    .romOeN(romOeN), .casN(casN), .perCeN(perCeN), .killN(killN),
    .locDsN(locDsN), .vpaN(vpaN), .dtackN(dtackN)
  );
endmodule

// File: rtl/busGlueChk.sv
module busGlueChk #(
  parameter int ADDR_W = 20,
  parameter int SEL_LO = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              asN,
  input logic              dsN,
  input logic [2:0]        fc,
  input logic              expDtackN,
  input logic              romOeN,
  input logic [1:0]        casN,
  input logic              perCeN,
  input logic              killN,
  input logic              locDsN,
  input logic              expDsN,
  input logic              vpaN,
  input logic              dtackN
);
  logic extAddr;
  logic iackFc;
  assign extAddr = |addr[SEL_LO+3:SEL_LO+2];
  assign iackFc  = fc[1] && fc[0];

  p_rom_select_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && !iackFc && addr[SEL_LO+3:SEL_LO] == 4'b0000) |=> !romOeN);

  p_one_select_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~romOeN, ~casN, ~perCeN}));

  p_kill_on_ext_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && !iackFc && extAddr) |=> !killN);

  p_kill_blocks_locds_r4: assert property (@(posedge clk) disable iff (!rstN)
    !killN |-> locDsN);

  p_exp_ds_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    expDsN == dsN);

  p_vpa_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !vpaN |-> (romOeN && casN == 2'b11 && perCeN && killN && dtackN));

  p_local_ack_needs_ds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!dtackN && killN) |-> $past(!dsN));

  p_ext_ack_relay_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && !iackFc && extAddr) |=> (dtackN == $past(expDtackN)));

  p_as_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    asN |=> (romOeN && casN == 2'b11 && perCeN && killN && locDsN && vpaN && dtackN));
endmodule

bind busGlue busGlueChk #(.ADDR_W(ADDR_W), .SEL_LO(SEL_LO)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .asN(asN), .dsN(dsN), .fc(fc),
  .expDtackN(expDtackN), .romOeN(romOeN), .casN(casN), .perCeN(perCeN),
  .killN(killN), .locDsN(locDsN), .expDsN(expDsN), .vpaN(vpaN), .dtackN(dtackN)
);

// File: tb/sim_busGlue.sv
module sim_busGlue;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] addr = '0;
  logic        asN = 1'b1, dsN = 1'b1, rwN = 1'b1, expDtackN = 1'b1;
  logic [2:0]  fc = 3'b000;
  logic        romOeN, perCeN, killN, locDsN, expDsN, vpaN, dtackN;
  logic [1:0]  casN;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // reference model state
  int   dsRun = 0;
  logic eRom = 1, ePer = 1, eKill = 1, eLds = 1, eVpa = 1, eAck = 1;
  logic [1:0] eCas = 2'b11;

  always #2 clk = ~clk;

  busGlue u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .asN(asN), .dsN(dsN), .rwN(rwN),
    .fc(fc), .expDtackN(expDtackN), .romOeN(romOeN), .casN(casN),
    .perCeN(perCeN), .killN(killN), .locDsN(locDsN), .expDsN(expDsN),
    .vpaN(vpaN), .dtackN(dtackN)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eRom = 1; eCas = 2'b11; ePer = 1; eKill = 1; eLds = 1; eVpa = 1; eAck = 1;
      dsRun = 0;
    end else begin
      bit inIack, ext, isLocal, dev;
      inIack  = (fc[1] == 1'b1) && (fc[0] == 1'b1);
      ext     = !asN && !inIack && (addr[19] || addr[18]);
      isLocal = !asN && !inIack && !ext;
      eRom  = !(isLocal && addr[17:16] == 2'd0);
      ePer  = !(isLocal && addr[17:16] == 2'd1);
      eCas[0] = !(isLocal && addr[17:16] == 2'd2 && !addr[15]);
      eCas[1] = !(isLocal && addr[17:16] == 2'd2 && addr[15]);
      eKill = !ext;
      eLds  = asN || ext || dsN;
      eVpa  = !(!asN && inIack);
      dev   = isLocal && addr[17:16] != 2'd3;
      if (dev && !dsN) dsRun = dsRun + 1; else dsRun = 0;
      if (ext) eAck = expDtackN;
      else     eAck = !(dsRun >= 2);
    end
  end

  task automatic chk(string req, string nm, logic [1:0] act, logic [1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, nm, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R1", "romOeN", {1'b0, romOeN}, {1'b0, eRom});
    chk("R2", "casN",   casN, eCas);
    chk("R2", "perCeN", {1'b0, perCeN}, {1'b0, ePer});
    chk("R3", "killN",  {1'b0, killN}, {1'b0, eKill});
    chk("R4", "locDsN", {1'b0, locDsN}, {1'b0, eLds});
    chk("R5", "expDsN", {1'b0, expDsN}, {1'b0, dsN});
    chk("R6", "vpaN",   {1'b0, vpaN}, {1'b0, eVpa});
    chk("R7", "dtackN", {1'b0, dtackN}, {1'b0, eAck});
  endtask

  task automatic step(logic [19:0] a, logic as_, logic ds_, logic rw_,
                      logic [2:0] f, logic xa);
    addr = a; asN = as_; dsN = ds_; rwN = rw_; fc = f; expDtackN = xa;
    @(negedge clk);
    compareAll();
  endtask

  task automatic access(logic [19:0] a, logic rw_, logic [2:0] f, int len, logic xa);
    step(a, 1'b0, 1'b1, rw_, f, 1'b1);
    for (int i = 0; i < len; i++) step(a, 1'b0, 1'b0, rw_, f, xa);
    step(a, 1'b1, 1'b1, rw_, f, 1'b1);
    step(a, 1'b1, 1'b1, rw_, f, 1'b1);   // R9 release observed here
  endtask

  initial begin
    #800000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "resetOuts", {1'b0, &{romOeN, casN, perCeN, killN, locDsN, vpaN, dtackN}}, 2'b01);
    rstN = 1'b1;
    @(negedge clk);
    compareAll();
    access(20'h0_1234, 1'b1, 3'b110, 4, 1'b1);  // R1 ROM read, R7 ack
    access(20'h2_0010, 1'b0, 3'b101, 3, 1'b1);  // R2 cas0 write
    access(20'h2_8010, 1'b1, 3'b101, 3, 1'b1);  // R2 cas1
    access(20'h1_0004, 1'b0, 3'b101, 3, 1'b1);  // R2 peripheral
    access(20'h3_0000, 1'b1, 3'b101, 4, 1'b1);  // R2/R7 unused local: no ack
    access(20'h4_0000, 1'b1, 3'b101, 4, 1'b0);  // R3/R4/R8 external, port acks
    access(20'h8_0000, 1'b0, 3'b101, 4, 1'b1);  // R8 external, no port ack
    access(20'hF_FFFF, 1'b1, 3'b111, 4, 1'b0);  // R6 iack in ext space
    access(20'h0_0000, 1'b1, 3'b011, 3, 1'b1);  // R6 iack, low address
    // R7: data strobe dropping mid cycle restarts count
    step(20'h0_0100, 1'b0, 1'b0, 1'b1, 3'b110, 1'b1);
    step(20'h0_0100, 1'b0, 1'b1, 1'b1, 3'b110, 1'b1);
    step(20'h0_0100, 1'b0, 1'b0, 1'b1, 3'b110, 1'b1);
    step(20'h0_0100, 1'b0, 1'b0, 1'b1, 3'b110, 1'b1);
    step(20'h0_0100, 1'b1, 1'b1, 1'b1, 3'b110, 1'b1);
    for (int i = 0; i < 600; i++) begin
      logic [19:0] a;
      a = 20'($urandom);
      if ($urandom_range(0, 2) != 0) a[19:18] = 2'b00;
      step(a, ($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
           3'($urandom), 1'($urandom));
    end
    // R10: reset while an access is live
    step(20'h0_0000, 1'b0, 1'b0, 1'b1, 3'b110, 1'b1);
    rstN = 1'b0;
    #1;
    chk("R10", "resetMid", {1'b0, &{romOeN, casN, perCeN, killN, locDsN, vpaN, dtackN}}, 2'b01);
    @(negedge clk);
    rstN = 1'b1;
    step(20'h0_0000, 1'b1, 1'b1, 1'b1, 3'b110, 1'b1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule